// File: doc/BRIEF.md
# Prime-Bank Residue Address Mapper

This block turns a linear word address into a bank index and an in-bank word offset for a memory built from a prime number of banks, 2^K-1 of them, each holding 2^W words. The bank index is the address reduced modulo the bank count. The in-bank offset is the address reduced modulo the words per bank. The two moduli have no common factor, so every address below their product lands on its own (bank, offset) pair. No division is needed. Because the bank count is not a power of two, a run of accesses whose stride is a power of two spreads across all banks and does not pile onto one.

The modulo-(2^K-1) reduction uses no divider. The address is cut into K-bit chunks and the chunks are added. The sum is then folded repeatedly: the bits above position K are added back onto the low K bits (end-around carry). One fold takes one pipeline stage, and the number of folds comes from the parameters. A final step turns an all-ones residue into zero. The offset is the low W address bits, carried down the pipeline beside the residue. The mapper takes one address per cycle. Every result appears a fixed LATENCY cycles after its input, where LATENCY is the number of folds plus two. In the default configuration (K=3, W=4: 7 banks of 16 words, 7-bit address), LATENCY is 4. An address at or above 7*16=112 is flagged as an error. That range check is simply the top K address bits being all ones.

Top module: `prime_bank_mapper`

## Requirements
- R1: For a valid address x, outBank equals x mod (2^K-1) and is always below the bank count.
- R2: For a valid address x, outOffset equals x mod 2^W, that is the low W bits of x.
- R3: An accepted in-range address yields outValid high for exactly one cycle, LATENCY cycles later (4 in the default configuration). One address can be accepted every cycle with no bubbles.
- R4: An address x with x >= (2^K-1)*2^W raises outErr, not outValid, after the same LATENCY.
- R5: A cycle with inValid low produces no outValid and no outErr LATENCY cycles later.
- R6: outValid and outErr are never high together.
- R7: Over all valid addresses, the (outBank, outOffset) pairs are pairwise distinct.
- R8: For any base b < 2^W, the 2^K-1 addresses b + j*2^W (j = 0 .. 2^K-2) map to 2^K-1 distinct banks.
- R9: While rst (synchronous, active high) is asserted and in the cycle after it, outValid and outErr are low.
- R10: A residue whose folded value is all ones (x = 7 or 14 by default) reports bank 0. After the last fold the value never exceeds 2^K-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | An address is presented this cycle |
| inAddr | input | BANK_BITS+OFFSET_BITS | Linear word address |
| outValid | output | 1 | outBank and outOffset hold a mapped in-range address |
| outErr | output | 1 | The address issued LATENCY cycles ago was out of range |
| outBank | output | BANK_BITS | Bank index, 0 to 2^K-2 |
| outOffset | output | OFFSET_BITS | Word offset within the bank |

## Verification
The assertions assume that inValid and inAddr are known, defined values on every edge after reset. They also assume that the parameters give a prime bank count of the form 2^K-1. The bank-range and offset checks compare against inputs sampled exactly LATENCY cycles earlier. That comparison holds only because nothing stalls the pipeline. The stimulus drives the default configuration with fully defined inputs, changed only between clock edges, and covers every 7-bit address, including the whole out-of-range top group. It sends addresses back to back, then again with random idle gaps, and then in power-of-two strides.

// File: rtl/prime_bank_pkg.sv
package prime_bank_pkg;

  // Strobes from control to datapath: one load enable per register stage.
  typedef struct packed {
    logic        captureEn;
    logic [15:0] foldEn;
    logic        outEn;
  } dpStrobe_t;

  function automatic int chunkCount(input int k, input int aw);
    return (aw + k - 1) / k;
  endfunction

  // Largest possible sum of the K-bit chunks of an aw-bit address.
  function automatic longint maxChunkSum(input int k, input int aw);
    longint s;
    int     bits;
    s = 0;
    for (int i = 0; i < chunkCount(k, aw); i++) begin
      bits = aw - i * k;
      if (bits > k) bits = k;
      s = s + ((longint'(1) << bits) - 1);
    end
    return s;
  endfunction

  // Number of end-around folds needed to bring any value <= m0 to <= 2^k-1.
  function automatic int foldCount(input int k, input longint m0);
    longint mask, m, hi, a, b;
    int     n;
    mask = (longint'(1) << k) - 1;
    m    = m0;
    n    = 0;
    while (m > mask) begin
      hi = m >> k;
      a  = (m & mask) + hi;
      b  = mask + hi - 1;
      m  = (a > b) ? a : b;
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/prime_bank_ctrl.sv
module prime_bank_ctrl
  import prime_bank_pkg::*;
#(
  parameter int BANK_BITS = 3,
  parameter int NFOLD     = 2,
  parameter int LATENCY   = NFOLD + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [BANK_BITS-1:0] inHigh,
  output dpStrobe_t            strobe,
  output logic                 outValid,
  output logic                 outErr
);

  logic [LATENCY-1:0] occPipe;
  logic [LATENCY-1:0] errPipe;
  logic               rangeErr;

  // Address at or beyond banks*words exactly when the top K bits are all ones.
  assign rangeErr = inValid & (&inHigh);

  always_ff @(posedge clk) begin
    if (rst) begin
      occPipe <= '0;
      errPipe <= '0;
    end else begin
      occPipe <= {occPipe[LATENCY-2:0], inValid};
      errPipe <= {errPipe[LATENCY-2:0], rangeErr};
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.captureEn = inValid;
    for (int j = 0; j < NFOLD; j++) strobe.foldEn[j] = occPipe[j];
    strobe.outEn     = occPipe[NFOLD];
  end

  assign outValid = occPipe[LATENCY-1] & ~errPipe[LATENCY-1];
  assign outErr   = occPipe[LATENCY-1] &  errPipe[LATENCY-1];

  // R4: an error result traces back to an out-of-range address LATENCY cycles ago
  assert_err_source_R4: assert property (@(posedge clk) disable iff (rst)
    outErr |-> $past(inValid && (&inHigh), LATENCY));

  // R3: a valid result traces back to an in-range address LATENCY cycles ago
  assert_valid_source_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid && !(&inHigh), LATENCY));

endmodule

// File: rtl/prime_bank_dp.sv
module prime_bank_dp
  import prime_bank_pkg::*;
#(
  parameter int BANK_BITS   = 3,
  parameter int OFFSET_BITS = 4,
  parameter int ADDR_W      = BANK_BITS + OFFSET_BITS,
  parameter int SUM_W       = 4,
  parameter int NFOLD       = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dpStrobe_t              strobe,
  input  logic [ADDR_W-1:0]      inAddr,
  output logic [BANK_BITS-1:0]   outBank,
  output logic [OFFSET_BITS-1:0] outOffset
);

  localparam int CHUNKS = chunkCount(BANK_BITS, ADDR_W);
  localparam int PAD_W  = CHUNKS * BANK_BITS;
  localparam logic [BANK_BITS-1:0] ONES = '1;

  logic [PAD_W-1:0]       padAddr;
  logic [SUM_W-1:0]       chunkSum;
  logic [SUM_W-1:0]       foldReg  [0:NFOLD];
  logic [SUM_W-1:0]       foldNext [1:NFOLD];
  logic [OFFSET_BITS-1:0] offReg   [0:NFOLD];
  logic [BANK_BITS-1:0]   lastLow;
  logic                   foldEnUnused;

  assign padAddr      = PAD_W'(inAddr);
  assign foldEnUnused = ^(strobe.foldEn >> NFOLD);

  // Sum of K-bit chunks: each chunk has weight 2^(iK) = 1 mod (2^K-1).
  always_comb begin
    chunkSum = '0;
    for (int i = 0; i < CHUNKS; i++)
      chunkSum = chunkSum + SUM_W'(padAddr[i*BANK_BITS +: BANK_BITS]);
  end

  // One end-around fold per stage: high part added back onto the low K bits.
  always_comb begin
    for (int j = 1; j <= NFOLD; j++)
      foldNext[j] = SUM_W'(foldReg[j-1][BANK_BITS-1:0]) + (foldReg[j-1] >> BANK_BITS);
  end

  always_ff @(posedge clk) begin
    if (strobe.captureEn) begin
      foldReg[0] <= chunkSum;
      offReg[0]  <= inAddr[OFFSET_BITS-1:0];
    end
    for (int j = 1; j <= NFOLD; j++) begin
      if (strobe.foldEn[j-1]) begin
        foldReg[j] <= foldNext[j];
        offReg[j]  <= offReg[j-1];
      end
    end
  end

  assign lastLow = foldReg[NFOLD][BANK_BITS-1:0];

  // All-ones is the second encoding of zero in ones'-complement residue.
  always_ff @(posedge clk) begin
    if (strobe.outEn) begin
      outBank   <= (lastLow == ONES) ? '0 : lastLow;
      outOffset <= offReg[NFOLD];
    end
  end

  // R10: after the last fold the residue fits in K bits
  assert_fold_bound_R10: assert property (@(posedge clk) disable iff (rst)
    strobe.outEn |-> (foldReg[NFOLD] <= SUM_W'(ONES)));

endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper
  import prime_bank_pkg::*;
#(
  parameter int BANK_BITS   = 3,
  parameter int OFFSET_BITS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             inValid,
  input  logic [BANK_BITS+OFFSET_BITS-1:0] inAddr,
  output logic                             outValid,
  output logic                             outErr,
  output logic [BANK_BITS-1:0]             outBank,
  output logic [OFFSET_BITS-1:0]           outOffset
);

  localparam int     ADDR_W    = BANK_BITS + OFFSET_BITS;
  localparam int     NUM_BANKS = (1 << BANK_BITS) - 1;
  localparam longint SUM_MAX   = maxChunkSum(BANK_BITS, ADDR_W);
  localparam int     SUM_W     = $clog2(SUM_MAX + 1);
  localparam int     NFOLD     = foldCount(BANK_BITS, SUM_MAX);
  localparam int     LATENCY   = NFOLD + 2;

  dpStrobe_t strobe;

  prime_bank_ctrl #(
    .BANK_BITS(BANK_BITS), .NFOLD(NFOLD), .LATENCY(LATENCY)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .inHigh(inAddr[ADDR_W-1:OFFSET_BITS]),
    .strobe(strobe), .outValid(outValid), .outErr(outErr)
  );

  prime_bank_dp #(
    .BANK_BITS(BANK_BITS), .OFFSET_BITS(OFFSET_BITS), .ADDR_W(ADDR_W),
    .SUM_W(SUM_W), .NFOLD(NFOLD)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inAddr(inAddr),
    .outBank(outBank), .outOffset(outOffset)
  );

  // R1: bank index stays below the prime bank count
  assert_bank_range_R1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outBank < BANK_BITS'(NUM_BANKS)));

  // R2: offset equals the low address bits presented LATENCY cycles earlier
  assert_offset_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outOffset == $past(inAddr[OFFSET_BITS-1:0], LATENCY)));

  // R5: no result without an accepted address
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
    (outValid || outErr) |-> $past(inValid, LATENCY));

  // R6: flags are exclusive
  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outErr));

endmodule

// File: tb/tb_prime_bank_mapper.sv
`timescale 1ns/1ps
module tb_prime_bank_mapper;

  localparam int K   = 3;
  localparam int W   = 4;
  localparam int AW  = K + W;
  localparam int NB  = 7;
  localparam int NW  = 16;
  localparam int LAT = 4;
  localparam int NA  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [AW-1:0] inAddr = '0;
  logic          outValid, outErr;
  logic [K-1:0]  outBank;
  logic [W-1:0]  outOffset;

  prime_bank_mapper #(.BANK_BITS(K), .OFFSET_BITS(W)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inAddr(inAddr),
    .outValid(outValid), .outErr(outErr), .outBank(outBank), .outOffset(outOffset)
  );

  always #2.5 clk = ~clk;

  int  cyc = 0;
  int  checks = 0;
  int  failures = 0;
  bit  monOn = 1'b0;
  bit  done = 1'b0;
  int  qAddr[$];
  int  qDue[$];
  int  gotBank[NA];
  int  gotOff[NA];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic drive(input bit v, input int a);
    @(negedge clk);
    inValid = v;
    inAddr  = AW'(a);
    if (v) begin
      qAddr.push_back(a);
      qDue.push_back(cyc + LAT);
    end
  endtask

  // Scoreboard: compare at the sample point LAT edges after issue.
  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (qDue.size() > 0 && qDue[0] == cyc) begin
        int a;
        a = qAddr.pop_front();
        void'(qDue.pop_front());
        if (a >= NB * NW) begin
          check(outErr == 1'b1, "R4 outErr", int'(outErr), 1);
          check(outValid == 1'b0, "R4/R6 outValid on error", int'(outValid), 0);
        end else begin
          check(outValid == 1'b1, "R3 outValid", int'(outValid), 1);
          check(outErr == 1'b0, "R6 outErr on valid", int'(outErr), 0);
          check(int'(outBank) == a % NB, "R1 bank", int'(outBank), a % NB);
          check(int'(outOffset) == a % NW, "R2 offset", int'(outOffset), a % NW);
          gotBank[a] = int'(outBank);
          gotOff[a]  = int'(outOffset);
        end
      end else if (outValid || outErr) begin
        check(1'b0, "R5 spurious output", int'({outValid, outErr}), 0);
      end
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      failures++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 20000);
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) begin
      gotBank[i] = -1;
      gotOff[i]  = -1;
    end
    repeat (3) @(negedge clk);
    // R9: quiet during reset
    check(outValid == 1'b0, "R9 outValid in reset", int'(outValid), 0);
    check(outErr == 1'b0, "R9 outErr in reset", int'(outErr), 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0 && outErr == 1'b0, "R9 after reset", int'({outValid, outErr}), 0);
    monOn = 1'b1;

    // R1-R4: every address back to back, including the out-of-range group
    for (int a = 0; a < NA; a++) drive(1'b1, a);
    // R5: idle cycles must stay silent
    for (int i = 0; i < LAT + 4; i++) drive(1'b0, 0);

    // Descending sweep with random bubbles
    for (int a = NA - 1; a >= 0; a--) begin
      drive(1'b1, a);
      if ($urandom % 3 == 0) drive(1'b0, 0);
    end
    for (int i = 0; i < LAT + 2; i++) drive(1'b0, 0);

    // R8 stimulus: power-of-two stride runs
    for (int b = 0; b < NW; b++)
      for (int j = 0; j < NB; j++) drive(1'b1, b + j * NW);
    for (int i = 0; i < LAT + 4; i++) drive(1'b0, 0);

    check(qDue.size() == 0, "R3 all results returned", qDue.size(), 0);

    // R10: all-ones residue reports bank 0
    check(gotBank[7] == 0, "R10 addr 7", gotBank[7], 0);
    check(gotBank[14] == 0, "R10 addr 14", gotBank[14], 0);
    check(gotBank[16] == 2 && gotOff[16] == 0, "R1 addr 16", gotBank[16], 2);
    check(gotBank[111] == 6 && gotOff[111] == 15, "R1 addr 111", gotBank[111], 6);

    // R7: uniqueness over all valid addresses
    begin
      bit seen[NB * NW];
      int dups;
      dups = 0;
      for (int i = 0; i < NB * NW; i++) seen[i] = 1'b0;
      for (int a = 0; a < NB * NW; a++) begin
        int key;
        key = gotBank[a] * NW + gotOff[a];
        if (key < 0 || key >= NB * NW || seen[key]) dups++;
        else seen[key] = 1'b1;
      end
      check(dups == 0, "R7 duplicate pairs", dups, 0);
    end

    // R8: each stride-16 group covers every bank
    for (int b = 0; b < NW; b++) begin
      int mask;
      mask = 0;
      for (int j = 0; j < NB; j++)
        if (gotBank[b + j * NW] >= 0) mask = mask | (1 << gotBank[b + j * NW]);
      check(mask == 127, "R8 stride bank set", mask, 127);
    end

    finishRun();
  end

endmodule